// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the addressing information of an already decoded instruction into the value that the execute stage needs. That value is an immediate operand, a register operand or a 16-bit effective address. It takes a 4-bit mode code, a 16-bit address field, two register selects and the current program counter. It reads two operands through a combinational register-file read port and forms every address with a single shared adder. The result is registered and comes with an operand-valid strobe and a kind code.

Every mode except one completes in one clock: the strobe rises on the edge after the instruction is accepted. In pointer-through-memory mode the address field names a memory word that holds the real address. For that mode the unit raises a level request on a simple request/valid memory port, holds `busy` high and waits as long as the memory needs. It then returns the fetched word as the effective address. While `busy` is high, new instructions are not accepted. Mode codes with no assigned meaning raise a one-cycle `illegal` flag and produce no valid output.

Top module: `ea_gen_unit`

## Requirements
- R1: While `rst_n` is low and right after it is released, `out_valid`, `illegal`, `implied_flag`, `busy` and `mem_req` are all 0.
- R2: Immediate mode (code 1): one cycle after an accepted `start`, `out_valid`=1, `out_kind`=1 and `out_value` equals the address field.
- R3: Register mode (code 2): one cycle after acceptance, `out_valid`=1, `out_kind`=2 and `out_value` is the register selected by `rsel_a`.
- R4: Direct mode (code 3): one cycle after acceptance, `out_kind`=3 and `out_value` equals the address field.
- R5: Displacement mode (code 5): `out_kind`=3 and `out_value` = address field + register[`rsel_a`], modulo 2^16.
- R6: PC-relative mode (code 6): `out_kind`=3 and `out_value` = address field + `pc`, modulo 2^16.
- R7: Indexed mode (code 7): `out_kind`=3 and `out_value` = register[`rsel_a`] + the low 8 bits of the address field sign-extended to 16 bits, modulo 2^16.
- R8: Based-indexed mode (code 8): `out_kind`=3 and `out_value` = register[`rsel_a`] + register[`rsel_b`], modulo 2^16.
- R9: Indirect mode (code 4): one cycle after acceptance, `mem_req`=1, `busy`=1 and `mem_addr` equals the address field. These hold, with no valid output, until `mem_rvalid` is seen. One cycle later `out_valid`=1, `out_kind`=3, `out_value` is the returned `mem_rdata`, and `busy` and `mem_req` are 0.
- R10: A `start` that arrives while `busy` is high is ignored. It produces no output and does not change `mem_addr`.
- R11: Implied mode (code 0): one cycle after acceptance, `out_valid`=1, `implied_flag`=1, `out_kind`=0 and `out_value`=0. `implied_flag` is 0 for every other result.
- R12: Mode codes 9 to 15: one cycle after acceptance, `illegal`=1 for one cycle and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Decoded instruction present this cycle |
| mode | input | 4 | Addressing mode code |
| addr_field | input | 16 | Address/constant field of the instruction |
| rsel_a | input | 3 | First register select (base or operand) |
| rsel_b | input | 3 | Second register select (index) |
| pc | input | 16 | Current program counter |
| rf_sel_a | output | 3 | Register-file read select, port A |
| rf_sel_b | output | 3 | Register-file read select, port B |
| rf_data_a | input | 16 | Register-file read data, port A (same cycle) |
| rf_data_b | input | 16 | Register-file read data, port B (same cycle) |
| mem_req | output | 1 | Pointer read request, held until answered |
| mem_addr | output | 16 | Address of the pointer word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Pointer read in progress; start is ignored |
| out_valid | output | 1 | Result strobe |
| out_kind | output | 2 | 0 none, 1 immediate, 2 register, 3 address |
| out_value | output | 16 | Operand or effective address |
| implied_flag | output | 1 | Result belongs to an implied-operand instruction |
| illegal | output | 1 | Unassigned mode code was accepted |

## Verification
A wrong operand-select decode shows at the ports one cycle after acceptance, as a wrong `out_value` or `out_kind` for that mode. This is most visible with wrapping sums and negative short displacements. A stuck or early-exiting wait state shows either as a valid strobe before `mem_rvalid`, or as `busy` and `mem_req` lingering past the returned word. A start leaking through while busy shows as an extra strobe or a moved `mem_addr` within one cycle. A random mix of all sixteen codes with varying memory delays covers the rest.

// File: rtl/ea_pkg.sv
// Shared codes for the effective address generation unit.
// Assumes: 4-bit mode codes, 2-bit result kind codes.
package ea_pkg;
    typedef enum logic [3:0] {
        MD_IMPLIED  = 4'd0,
        MD_IMM      = 4'd1,
        MD_REG      = 4'd2,
        MD_DIRECT   = 4'd3,
        MD_INDIRECT = 4'd4,
        MD_DISP     = 4'd5,
        MD_PCREL    = 4'd6,
        MD_INDEXED  = 4'd7,
        MD_BASEIDX  = 4'd8
    } ea_mode_e;

    typedef enum logic [1:0] {
        KD_NONE = 2'd0,
        KD_IMM  = 2'd1,
        KD_REG  = 2'd2,
        KD_ADDR = 2'd3
    } ea_kind_e;

    // Left adder operand source
    typedef enum logic [1:0] {
        LA_ZERO  = 2'd0,
        LA_FIELD = 2'd1,
        LA_SHORT = 2'd2,
        LA_REGB  = 2'd3
    } ea_lsel_e;

    // Right adder operand source
    typedef enum logic [1:0] {
        RB_ZERO = 2'd0,
        RB_REGA = 2'd1,
        RB_PC   = 2'd2
    } ea_rsel_e;
endpackage

// File: rtl/ea_mode_decode.sv
// Mode decoder: maps a 4-bit mode code onto adder operand selects,
// result kind and control class. Purely combinational.
// Assumes: codes above the last assigned mode are illegal.
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [3:0] mode,
    output ea_lsel_e   lsel,
    output ea_rsel_e   rsel,
    output ea_kind_e   kind,
    output logic       legal,
    output logic       indirect,
    output logic       implied
);
    // Decode one mode into its operand routing
    always_comb begin
        lsel     = LA_ZERO;
        rsel     = RB_ZERO;
        kind     = KD_ADDR;
        legal    = 1'b1;
        indirect = 1'b0;
        implied  = 1'b0;
        case (mode)
            MD_IMPLIED:  begin kind = KD_NONE; implied = 1'b1; end
            MD_IMM:      begin lsel = LA_FIELD; kind = KD_IMM; end
            MD_REG:      begin rsel = RB_REGA; kind = KD_REG; end
            MD_DIRECT:   lsel = LA_FIELD;
            MD_INDIRECT: begin lsel = LA_FIELD; indirect = 1'b1; end
            MD_DISP:     begin lsel = LA_FIELD; rsel = RB_REGA; end
            MD_PCREL:    begin lsel = LA_FIELD; rsel = RB_PC; end
            MD_INDEXED:  begin lsel = LA_SHORT; rsel = RB_REGA; end
            MD_BASEIDX:  begin lsel = LA_REGB; rsel = RB_REGA; end
            default:     begin legal = 1'b0; kind = KD_NONE; end
        endcase
    end
endmodule

// File: rtl/ea_sum.sv
// Shared address adder with two operand multiplexers.
// Assumes: DISP_W <= AW; the short displacement is sign-extended;
// the sum wraps modulo 2^AW.
module ea_sum
    import ea_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DISP_W = 8
) (
    input  ea_lsel_e        lsel,
    input  ea_rsel_e        rsel,
    input  logic [AW-1:0]   field,
    input  logic [AW-1:0]   reg_a,
    input  logic [AW-1:0]   reg_b,
    input  logic [AW-1:0]   pc,
    output logic [AW-1:0]   sum
);
    logic [AW-1:0] short_ext;
    logic [AW-1:0] left_op;
    logic [AW-1:0] right_op;

    // Sign-extend the short displacement, or pass the field when widths match
    generate
        if (DISP_W < AW) begin : g_sext
            assign short_ext = {{(AW-DISP_W){field[DISP_W-1]}}, field[DISP_W-1:0]};
        end else begin : g_full
            assign short_ext = field;
        end
    endgenerate

    // Select left operand
    always_comb begin
        case (lsel)
            LA_FIELD: left_op = field;
            LA_SHORT: left_op = short_ext;
            LA_REGB:  left_op = reg_b;
            default:  left_op = '0;
        endcase
    end

    // Select right operand
    always_comb begin
        case (rsel)
            RB_REGA: right_op = reg_a;
            RB_PC:   right_op = pc;
            default: right_op = '0;
        endcase
    end

    // Wrapping add
    assign sum = left_op + right_op;
endmodule

// File: rtl/ea_indirect_ctl.sv
// Pointer-read controller: on launch latches the pointer address and
// holds a level request until the memory answers with read-valid.
// Assumes: launch only arrives while idle; one outstanding read.
module ea_indirect_ctl #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [AW-1:0] ptr,
    input  logic          mem_rvalid,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          done
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;
    st_e state;

    // Advance the wait state and latch the pointer address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mem_addr <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    state    <= ST_WAIT;
                    mem_addr <= ptr;
                end
                default: if (mem_rvalid) state <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state == ST_WAIT);
    assign mem_req = busy;
    assign done    = busy && mem_rvalid;
endmodule

// File: rtl/ea_gen_unit.sv
// Effective address generation unit top level.
// Accepts a decoded instruction when start is high and busy is low,
// registers the operand/effective address one cycle later, or runs a
// pointer read through memory for indirect mode.
// Assumes: register-file read data arrives combinationally in the
// cycle the selects are presented.
module ea_gen_unit
    import ea_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NREG   = 8,
    parameter int DISP_W = 8,
    localparam int RSW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     mode,
    input  logic [AW-1:0]  addr_field,
    input  logic [RSW-1:0] rsel_a,
    input  logic [RSW-1:0] rsel_b,
    input  logic [AW-1:0]  pc,
    output logic [RSW-1:0] rf_sel_a,
    output logic [RSW-1:0] rf_sel_b,
    input  logic [AW-1:0]  rf_data_a,
    input  logic [AW-1:0]  rf_data_b,
    output logic           mem_req,
    output logic [AW-1:0]  mem_addr,
    input  logic           mem_rvalid,
    input  logic [AW-1:0]  mem_rdata,
    output logic           busy,
    output logic           out_valid,
    output logic [1:0]     out_kind,
    output logic [AW-1:0]  out_value,
    output logic           implied_flag,
    output logic           illegal
);
    ea_lsel_e      dec_lsel;
    ea_rsel_e      dec_rsel;
    ea_kind_e      dec_kind;
    logic          dec_legal;
    logic          dec_ind;
    logic          dec_impl;
    logic [AW-1:0] sum;
    logic          accept;
    logic          launch;
    logic          ind_done;

    assign rf_sel_a = rsel_a;
    assign rf_sel_b = rsel_b;

    ea_mode_decode u_dec (
        .mode     (mode),
        .lsel     (dec_lsel),
        .rsel     (dec_rsel),
        .kind     (dec_kind),
        .legal    (dec_legal),
        .indirect (dec_ind),
        .implied  (dec_impl)
    );

    ea_sum #(.AW(AW), .DISP_W(DISP_W)) u_sum (
        .lsel  (dec_lsel),
        .rsel  (dec_rsel),
        .field (addr_field),
        .reg_a (rf_data_a),
        .reg_b (rf_data_b),
        .pc    (pc),
        .sum   (sum)
    );

    assign accept = start && !busy;
    assign launch = accept && dec_legal && dec_ind;

    ea_indirect_ctl #(.AW(AW)) u_ind (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .ptr        (sum),
        .mem_rvalid (mem_rvalid),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .busy       (busy),
        .done       (ind_done)
    );

    // Register the result strobe, kind, value and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_kind     <= KD_NONE;
            out_value    <= '0;
            implied_flag <= 1'b0;
            illegal      <= 1'b0;
        end else begin
            out_valid    <= 1'b0;
            implied_flag <= 1'b0;
            illegal      <= 1'b0;
            if (ind_done) begin
                out_valid <= 1'b1;
                out_kind  <= KD_ADDR;
                out_value <= mem_rdata;
            end else if (accept && !dec_legal) begin
                illegal <= 1'b1;
            end else if (accept && !dec_ind) begin
                out_valid    <= 1'b1;
                out_kind     <= dec_kind;
                out_value    <= sum;
                implied_flag <= dec_impl;
            end
        end
    end
endmodule

// File: rtl/ea_gen_unit_chk.sv
// Assertion checker for ea_gen_unit, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module ea_gen_unit_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [3:0]    mode,
    input logic [AW-1:0] addr_field,
    input logic          busy,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic [AW-1:0] mem_rdata,
    input logic          out_valid,
    input logic [1:0]    out_kind,
    input logic [AW-1:0] out_value,
    input logic          implied_flag,
    input logic          illegal
);
    AST_IMM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd1) |=> (out_valid && out_kind == 2'd1 && out_value == $past(addr_field))); // R2

    AST_IND_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd4) |=> (mem_req && busy && !out_valid && mem_addr == $past(addr_field))); // R9

    AST_IND_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (out_valid && out_kind == 2'd3 && out_value == $past(mem_rdata) && !busy)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R9

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_rvalid) |=> !out_valid); // R10

    AST_IMPLIED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        implied_flag |-> (out_valid && out_kind == 2'd0 && out_value == '0)); // R11

    AST_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode >= 4'd9) |=> (illegal && !out_valid)); // R12

    AST_NO_VALID_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(illegal && out_valid)); // R12
endmodule

bind ea_gen_unit ea_gen_unit_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .mode         (mode),
    .addr_field   (addr_field),
    .busy         (busy),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_rvalid   (mem_rvalid),
    .mem_rdata    (mem_rdata),
    .out_valid    (out_valid),
    .out_kind     (out_kind),
    .out_value    (out_value),
    .implied_flag (implied_flag),
    .illegal      (illegal)
);

// File: tb/tb_ea_gen_unit.sv
// Bench for ea_gen_unit: directed corners plus seeded random mix.
module tb_ea_gen_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  mode;
    logic [15:0] addr_field;
    logic [2:0]  rsel_a, rsel_b;
    logic [15:0] pc;
    logic [2:0]  rf_sel_a, rf_sel_b;
    logic [15:0] rf_data_a, rf_data_b;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid;
    logic [15:0] mem_rdata;
    logic        busy, out_valid, implied_flag, illegal;
    logic [1:0]  out_kind;
    logic [15:0] out_value;

    logic [15:0] regs [8];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign rf_data_a = regs[rf_sel_a];
    assign rf_data_b = regs[rf_sel_b];

    ea_gen_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .rsel_a(rsel_a), .rsel_b(rsel_b), .pc(pc),
        .rf_sel_a(rf_sel_a), .rf_sel_b(rf_sel_b),
        .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .out_valid(out_valid), .out_kind(out_kind),
        .out_value(out_value), .implied_flag(implied_flag), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] m);
        case (m)
            4'd0: return "R11";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R9";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [1:0] exp_kind(input logic [3:0] m);
        case (m)
            4'd0: return 2'd0;
            4'd1: return 2'd1;
            4'd2: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [15:0] exp_value(input logic [3:0] m, input logic [15:0] af,
                                              input logic [15:0] ra, input logic [15:0] rb,
                                              input logic [15:0] p);
        case (m)
            4'd1, 4'd3, 4'd4: return af;
            4'd2: return ra;
            4'd5: return af + ra;
            4'd6: return af + p;
            4'd7: return ra + {{8{af[7]}}, af[7:0]};
            4'd8: return ra + rb;
            default: return 16'h0;
        endcase
    endfunction

    // One instruction; for indirect mode, dly wait cycles with ignored starts
    task automatic run_op(input logic [3:0] m, input logic [15:0] af, input logic [2:0] a,
                          input logic [2:0] b, input logic [15:0] p, input int dly,
                          input logic [15:0] rd);
        logic [15:0] ev;
        string r;
        r = req_of(m);
        @(negedge clk);
        start = 1'b1; mode = m; addr_field = af; rsel_a = a; rsel_b = b; pc = p;
        ev = exp_value(m, af, regs[a], regs[b], p);
        @(negedge clk);
        start = 1'b0;
        if (m == 4'd4) begin
            chk(mem_req && busy && !out_valid, "R9", {mem_req, busy, out_valid}, 3'b110);
            chk(mem_addr == af, "R9", mem_addr, af);
            for (int i = 0; i < dly; i++) begin
                start = 1'b1; mode = 4'd1; addr_field = ~af;
                @(negedge clk);
                chk(!out_valid && mem_req, "R10", {out_valid, mem_req}, 2'b01);
                chk(mem_addr == af, "R10", mem_addr, af);
            end
            start = 1'b0;
            mem_rvalid = 1'b1; mem_rdata = rd;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk(out_valid && out_kind == 2'd3, "R9", {out_valid, out_kind}, 3'b111);
            chk(out_value == rd, "R9", out_value, rd);
            chk(!busy && !mem_req, "R9", {busy, mem_req}, 2'b00);
        end else if (m >= 4'd9) begin
            chk(illegal && !out_valid, "R12", {illegal, out_valid}, 2'b10);
        end else begin
            chk(out_valid && out_kind == exp_kind(m), r, {out_valid, out_kind}, {1'b1, exp_kind(m)});
            chk(out_value == ev, r, out_value, ev);
            chk(implied_flag == (m == 4'd0), "R11", implied_flag, (m == 4'd0));
        end
    endtask

    initial begin
        #(8 * 150000);
        $display("FAIL watchdog expired actual=running expected=done");
        errors++;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 8; i++) regs[i] = 16'($urandom);
        rst_n = 1'b0; start = 1'b0; mode = '0; addr_field = '0;
        rsel_a = '0; rsel_b = '0; pc = '0; mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && !illegal && !implied_flag && !busy && !mem_req, "R1",
            {out_valid, illegal, implied_flag, busy, mem_req}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !illegal && !busy && !mem_req, "R1",
            {out_valid, illegal, busy, mem_req}, 4'b0);

        // Directed corners
        regs[3] = 16'h0002; regs[5] = 16'hFFFF;
        run_op(4'd0, 16'h1234, 3'd0, 3'd0, 16'h0, 0, 16'h0);        // R11 implied
        run_op(4'd1, 16'hBEEF, 3'd0, 3'd0, 16'h0, 0, 16'h0);        // R2
        run_op(4'd2, 16'h0000, 3'd3, 3'd0, 16'h0, 0, 16'h0);        // R3
        run_op(4'd3, 16'h4000, 3'd0, 3'd0, 16'h0, 0, 16'h0);        // R4
        run_op(4'd5, 16'hFFFF, 3'd3, 3'd0, 16'h0, 0, 16'h0);        // R5 wrap -> 0001
        run_op(4'd6, 16'h8000, 3'd0, 3'd0, 16'h8001, 0, 16'h0);     // R6 wrap -> 0001
        run_op(4'd7, 16'h0080, 3'd3, 3'd0, 16'h0, 0, 16'h0);        // R7 negative short disp
        run_op(4'd8, 16'h0000, 3'd5, 3'd3, 16'h0, 0, 16'h0);        // R8 wrap -> 0001
        run_op(4'd4, 16'h0100, 3'd0, 3'd0, 16'h0, 0, 16'hCAFE);     // R9 immediate answer
        run_op(4'd4, 16'h0200, 3'd0, 3'd0, 16'h0, 4, 16'h1357);     // R9 and R10 with wait
        run_op(4'd15, 16'h0, 3'd0, 3'd0, 16'h0, 0, 16'h0);          // R12
        run_op(4'd9, 16'h0, 3'd0, 3'd0, 16'h0, 0, 16'h0);           // R12

        // Seeded random mix
        for (int n = 0; n < 400; n++) begin
            regs[$urandom_range(0, 7)] = 16'($urandom);
            run_op(4'($urandom_range(0, 15)), 16'($urandom), 3'($urandom_range(0, 7)),
                   3'($urandom_range(0, 7)), 16'($urandom), int'($urandom_range(0, 3)),
                   16'($urandom));
        end

        @(negedge clk);
        chk(!out_valid && !busy, "R1", {out_valid, busy}, 2'b00);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule